// File: doc/BRIEF.md
# Up-Counting PWM Time Base with Event Trigger

This block is the timing core of a PWM channel used to pace an analog-to-digital converter. A counter runs upward from zero to a programmed period, then wraps to zero. It advances at a rate set by two cascaded clock dividers. Two compare registers sit alongside the counter. The period and both compare values are double-buffered: software writes a pending copy, and the hardware copies it into the working register only when the counter wraps to zero. A write therefore never tears a period that is already running.

Three trigger paths watch the counter. Two of them produce start-of-conversion strobes for a converter. The third produces an interrupt request. Each path has its own enable bit, its own event select and its own prescale setting, which lets it fire on every Nth qualifying event. Every pulse also sets a bit in a shared flag register, and software clears those bits by writing ones. While the interrupt flag is set, the interrupt path stays silent, so an unserviced request cannot be lost under a second one.

Top module: `pwm_evt_trig`

## Requirements
- R1: The counter starts at 0 and advances by one per time-base tick. In the tick where it equals the working period it returns to 0, and it never exceeds the working period.
- R2: A time-base tick occurs once every H*K system clocks. H is 1 for fast-divider code 0 and twice the code otherwise. K is 2 to the power of the slow-divider code. The fast code is field [2:0] and the slow code is field [5:3] of register address 3, and a write to it takes effect at once.
- R3: Writes to compare A (address 1) and compare B (address 2) go to pending copies. The working compare values change only in the cycle where the counter becomes 0.
- R4: Writes to the period (address 0) go to a pending copy, which becomes the working period in the cycle where the counter becomes 0. The period reset value is 63.
- R5: Each path selects its event with a 3-bit code: 0 none, 1 counter equals zero, 2 counter equals period, 3 counter equals compare A while rising, 4 counter equals compare B while rising.
- R6: Address 4 holds one byte per path: interrupt in bits [7:0], first strobe in [15:8], second strobe in [23:16]. Within a byte, bit 0 is the enable, bits [3:1] are the event select and bits [5:4] are the prescale. A path with its enable clear produces no pulse.
- R7: A prescale of N (1 to 3) makes a path pulse on every Nth qualifying event. A prescale of 0 produces no pulse.
- R8: The flag register shows the interrupt flag at bit 0, the first-strobe flag at bit 2 and the second-strobe flag at bit 3, with bit 1 always 0. Each flag is set the cycle after its pulse. Writing ones to address 5 clears the matching flags and leaves the others untouched.
- R9: While the interrupt flag is set, no interrupt pulse is produced. After it is cleared, the next selected event pulses again.
- R10: Each output pulse lasts one system clock, in the first clock in which the counter shows the matching value.
- R11: A compare value above the working period never produces a compare event.
- R12: During and right after reset, the counter, the flags and all three pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| soca_o | output | 1 | First start-of-conversion strobe |
| socb_o | output | 1 | Second start-of-conversion strobe |
| irq_o | output | 1 | Interrupt request pulse |
| ctr_o | output | 16 | Current counter value |
| flags_o | output | 4 | Event flag register |

## Verification
A wrong divider or counter state shows within one period as a wrong gap between strobes, or as a strobe that lands on a counter value other than the selected compare. A shadow register that loads early moves the next strobe inside the current period. That error appears one pulse after the write, as a gap shorter than the expected sum of the old and new periods. Flag and blocking faults appear one clock after a pulse, either as a flag register value other than 0xD with all paths armed, or as an interrupt pulse while its flag is still up.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;

   localparam int NUM_PATHS = 3;
   localparam int PS_W      = 2;
   localparam int SEL_W     = 3;
   localparam int CFG_W     = 1 + SEL_W + PS_W;
   localparam int FLAG_W    = 4;

   localparam int PATH_IRQ  = 0;
   localparam int PATH_SOCA = 1;
   localparam int PATH_SOCB = 2;

   localparam logic [2:0] ADR_PRD   = 3'd0;
   localparam logic [2:0] ADR_CMPA  = 3'd1;
   localparam logic [2:0] ADR_CMPB  = 3'd2;
   localparam logic [2:0] ADR_CLK   = 3'd3;
   localparam logic [2:0] ADR_TRIG  = 3'd4;
   localparam logic [2:0] ADR_FCLR  = 3'd5;

   typedef enum logic [SEL_W-1:0] {
      EV_NONE    = 3'd0,
      EV_ZERO    = 3'd1,
      EV_PRD     = 3'd2,
      EV_CMPA_UP = 3'd3,
      EV_CMPB_UP = 3'd4
   } evt_sel_e;

   typedef struct packed {
      logic [PS_W-1:0] prescale;
      evt_sel_e        sel;
      logic            en;
   } path_cfg_t;

   typedef struct packed {
      logic cmpb_up;
      logic cmpa_up;
      logic prd;
      logic zero;
   } evt_vec_t;

   function automatic int flag_pos(input int path);
      case (path)
         PATH_IRQ:  return 0;
         PATH_SOCA: return 2;
         default:   return 3;
      endcase
   endfunction

endpackage

// File: rtl/pwm_tb_clkdiv.sv
module pwm_tb_clkdiv #(
   parameter int HS_W  = 3,
   parameter int CK_W  = 3,
   parameter int DIV_W = HS_W + 1 + (1 << CK_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [HS_W-1:0] hs_code,
   input  logic [CK_W-1:0] ck_code,
   output logic            tick
);

   localparam int NEED_W = HS_W + 1 + (1 << CK_W);

   if (DIV_W < NEED_W) begin : g_bad_div_w
      $error("pwm_tb_clkdiv: DIV_W too small for largest divisor");
   end

   logic [HS_W:0]      hs_mult;
   logic [DIV_W-1:0]   divisor;
   logic [DIV_W-1:0]   cnt_q;

   always_comb begin
      if (hs_code == '0) hs_mult = (HS_W+1)'(1);
      else               hs_mult = {hs_code, 1'b0};
      divisor = DIV_W'(hs_mult) << ck_code;
   end

   assign tick = (cnt_q >= divisor - DIV_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (tick)  cnt_q <= '0;
      else            cnt_q <= cnt_q + DIV_W'(1);
   end

endmodule

// File: rtl/pwm_tb_core.sv
module pwm_tb_core
   import pwm_evt_pkg::*;
#(
   parameter int          CTR_W   = 16,
   parameter logic [15:0] PRD_RST = 16'd63
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             prd_wr,
   input  logic             cmpa_wr,
   input  logic             cmpb_wr,
   input  logic [CTR_W-1:0] wdata,
   output logic [CTR_W-1:0] ctr,
   output logic [CTR_W-1:0] prd_act,
   output logic [CTR_W-1:0] cmpa_act,
   output logic [CTR_W-1:0] cmpb_act,
   output evt_vec_t         evt
);

   logic [CTR_W-1:0] prd_sh, cmpa_sh, cmpb_sh;
   logic             fresh_q;
   logic             wrap;

   assign wrap = tick && (ctr >= prd_act);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prd_sh  <= CTR_W'(PRD_RST);
         cmpa_sh <= '0;
         cmpb_sh <= '0;
      end else begin
         if (prd_wr)  prd_sh  <= wdata;
         if (cmpa_wr) cmpa_sh <= wdata;
         if (cmpb_wr) cmpb_sh <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctr      <= '0;
         prd_act  <= CTR_W'(PRD_RST);
         cmpa_act <= '0;
         cmpb_act <= '0;
         fresh_q  <= 1'b1;
      end else begin
         fresh_q <= tick;
         if (wrap) begin
            ctr      <= '0;
            prd_act  <= prd_sh;
            cmpa_act <= cmpa_sh;
            cmpb_act <= cmpb_sh;
         end else if (tick) begin
            ctr <= ctr + CTR_W'(1);
         end
      end
   end

   always_comb begin
      evt.zero    = fresh_q && (ctr == '0);
      evt.prd     = fresh_q && (ctr == prd_act);
      evt.cmpa_up = fresh_q && (ctr == cmpa_act);
      evt.cmpb_up = fresh_q && (ctr == cmpb_act);
   end

endmodule

// File: rtl/pwm_evt_path.sv
module pwm_evt_path
   import pwm_evt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  path_cfg_t cfg,
   input  evt_vec_t  evt,
   input  logic      block,
   output logic      fire
);

   logic            sel_hit;
   logic            qual;
   logic [PS_W-1:0] cnt_q;
   logic [PS_W:0]   cnt_next;

   always_comb begin
      case (cfg.sel)
         EV_ZERO:    sel_hit = evt.zero;
         EV_PRD:     sel_hit = evt.prd;
         EV_CMPA_UP: sel_hit = evt.cmpa_up;
         EV_CMPB_UP: sel_hit = evt.cmpb_up;
         default:    sel_hit = 1'b0;
      endcase
   end

   assign qual     = cfg.en && sel_hit && !block;
   assign cnt_next = {1'b0, cnt_q} + (PS_W+1)'(1);
   assign fire     = qual && (cfg.prescale != '0) && (cnt_next >= {1'b0, cfg.prescale});

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!cfg.en)  cnt_q <= '0;
      else if (fire)     cnt_q <= '0;
      else if (qual)     cnt_q <= cnt_next[PS_W-1:0];
   end

endmodule

// File: rtl/pwm_evt_trig.sv
module pwm_evt_trig
   import pwm_evt_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter int          ADDR_W  = 3,
   parameter int          CTR_W   = 16,
   parameter int          HS_W    = 3,
   parameter int          CK_W    = 3,
   parameter logic [15:0] PRD_RST = 16'd63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              soca_o,
   output logic              socb_o,
   output logic              irq_o,
   output logic [CTR_W-1:0]  ctr_o,
   output logic [FLAG_W-1:0] flags_o
);

   localparam int DIV_W = HS_W + 1 + (1 << CK_W);

   if (DATA_W < 8 * NUM_PATHS || DATA_W < CTR_W || DATA_W < HS_W + CK_W) begin : g_bad_data_w
      $error("pwm_evt_trig: DATA_W too narrow for register fields");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("pwm_evt_trig: ADDR_W must cover six registers");
   end

   logic [HS_W-1:0]   hs_code_q;
   logic [CK_W-1:0]   ck_code_q;
   path_cfg_t         cfg_q [NUM_PATHS];
   logic [FLAG_W-1:0] flags_q;
   logic              tick;
   logic [CTR_W-1:0]  prd_act, cmpa_act, cmpb_act;
   evt_vec_t          evt;
   logic [NUM_PATHS-1:0] fire;
   logic [FLAG_W-1:0] flag_set, flag_clr;
   logic [2:0]        adr;

   assign adr = wr_addr[2:0];

   logic unused_wr;
   assign unused_wr = ^{wr_addr, wr_data};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_code_q <= '0;
         ck_code_q <= '0;
         for (int p = 0; p < NUM_PATHS; p++) cfg_q[p] <= '0;
      end else if (wr_en) begin
         if (adr == ADR_CLK) begin
            hs_code_q <= wr_data[HS_W-1:0];
            ck_code_q <= wr_data[HS_W +: CK_W];
         end
         if (adr == ADR_TRIG) begin
            for (int p = 0; p < NUM_PATHS; p++)
               cfg_q[p] <= path_cfg_t'(wr_data[p*8 +: CFG_W]);
         end
      end
   end

   pwm_tb_clkdiv #(
      .HS_W  (HS_W),
      .CK_W  (CK_W),
      .DIV_W (DIV_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .hs_code (hs_code_q),
      .ck_code (ck_code_q),
      .tick    (tick)
   );

   pwm_tb_core #(
      .CTR_W   (CTR_W),
      .PRD_RST (PRD_RST)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .prd_wr   (wr_en && adr == ADR_PRD),
      .cmpa_wr  (wr_en && adr == ADR_CMPA),
      .cmpb_wr  (wr_en && adr == ADR_CMPB),
      .wdata    (wr_data[CTR_W-1:0]),
      .ctr      (ctr_o),
      .prd_act  (prd_act),
      .cmpa_act (cmpa_act),
      .cmpb_act (cmpb_act),
      .evt      (evt)
   );

   for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
      logic blk;
      if (p == PATH_IRQ) begin : g_irq_blk
         assign blk = flags_q[flag_pos(PATH_IRQ)];
      end else begin : g_soc_blk
         assign blk = 1'b0;
      end
      pwm_evt_path u_path (
         .clk   (clk),
         .rst_n (rst_n),
         .cfg   (cfg_q[p]),
         .evt   (evt),
         .block (blk),
         .fire  (fire[p])
      );
   end

   always_comb begin
      flag_set = '0;
      for (int p = 0; p < NUM_PATHS; p++) flag_set[flag_pos(p)] = fire[p];
      flag_clr = (wr_en && adr == ADR_FCLR) ? wr_data[FLAG_W-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~flag_clr) | flag_set;
   end

   assign irq_o   = fire[PATH_IRQ];
   assign soca_o  = fire[PATH_SOCA];
   assign socb_o  = fire[PATH_SOCB];
   assign flags_o = flags_q;

endmodule

// File: rtl/pwm_evt_trig_chk.sv
module pwm_evt_trig_chk #(
   parameter int CTR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CTR_W-1:0] ctr,
   input logic [CTR_W-1:0] prd_act,
   input logic [CTR_W-1:0] cmpa_act,
   input logic             soca,
   input logic             irq,
   input logic [3:0]       flags
);

   // R1
   ctr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctr <= prd_act);

   // R1
   ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctr) |-> (ctr == '0 || {1'b0, ctr} == {1'b0, $past(ctr)} + 1'b1));

   // R3
   cmpa_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmpa_act) |-> ctr == '0);

   // R8
   soca_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soca |=> flags[2]);

   // R8
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> flags[0]);

   // R9
   irq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags[0] |-> !irq);

   // R8
   flag_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flags[1]);

endmodule

bind pwm_evt_trig pwm_evt_trig_chk #(.CTR_W(CTR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctr      (ctr_o),
   .prd_act  (prd_act),
   .cmpa_act (cmpa_act),
   .soca     (soca_o),
   .irq      (irq_o),
   .flags    (flags_o)
);

// File: tb/pwm_evt_trig_test.sv
module pwm_evt_trig_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        soca_o, socb_o, irq_o;
   logic [15:0] ctr_o;
   logic [3:0]  flags_o;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pwm_evt_trig uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .soca_o(soca_o), .socb_o(socb_o), .irq_o(irq_o), .ctr_o(ctr_o), .flags_o(flags_o)
   );

   // columns: period, cmpa, cmpb, fast code, slow code, expected strobe gap
   localparam int NV = 4;
   localparam int VEC [NV][6] = '{
      '{20, 5, 12, 0, 0, 21},
      '{10, 3,  3, 2, 0, 44},
      '{ 7, 0,  7, 1, 1, 32},
      '{15, 9,  2, 3, 2, 384}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [31:0] trig(input int i, input int a, input int b);
      return 32'(i) | (32'(a) << 8) | (32'(b) << 16);
   endfunction

   function automatic logic sig(input int which);
      case (which)
         0: return irq_o;
         1: return soca_o;
         default: return socb_o;
      endcase
   endfunction

   // waits for a pulse on the chosen output, starting at the next falling edge
   task automatic wait_pulse(input int which, input string req, output int t);
      t = -1;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (sig(which)) begin t = cyc; break; end
      end
      if (t < 0) chk(0, req, 0, 1);
   endtask

   task automatic wait_zero();
      int prev = ctr_o;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (ctr_o == 0 && prev != 0) return;
         prev = ctr_o;
      end
      chk(0, "R1 wrap", ctr_o, 0);
   endtask

   task automatic count_pulses(input int which, input int n, output int cnt);
      cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (sig(which)) cnt++;
      end
   endtask

   initial begin
      int t1, t2, t3, n;
      // R12: reset state
      repeat (3) @(negedge clk);
      chk(ctr_o == 0 && flags_o == 0, "R12 reset ctr/flags", {ctr_o, 12'(flags_o)}, 0);
      chk(!soca_o && !socb_o && !irq_o, "R12 reset pulses", {soca_o, socb_o, irq_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(flags_o == 0 && !soca_o && !socb_o && !irq_o, "R12 after release", flags_o, 0);

      // table: divider, compare placement, period gap, pulse width, flag set
      for (int v = 0; v < NV; v++) begin
         wr(3'd0, VEC[v][0]);
         wr(3'd1, VEC[v][1]);
         wr(3'd2, VEC[v][2]);
         wr(3'd3, VEC[v][3] | (VEC[v][4] << 3));
         wr(3'd4, trig(0, 8'h17, 8'h19));
         wait_zero();
         wr(3'd5, 32'hF);
         wait_pulse(1, "R5 soca seen", t1);
         wait_pulse(1, "R5 soca seen", t2);
         chk(ctr_o == VEC[v][1], "R5 soca at cmpa", ctr_o, VEC[v][1]);
         chk(t2 - t1 == VEC[v][5], "R2 divided period gap", t2 - t1, VEC[v][5]);
         @(negedge clk);
         chk(!soca_o, "R10 single-clock pulse", soca_o, 0);
         chk(flags_o[2] == 1'b1, "R8 soca flag", flags_o, 4);
         wait_pulse(2, "R5 socb seen", t3);
         chk(ctr_o == VEC[v][2], "R5 socb at cmpb", ctr_o, VEC[v][2]);
      end

      // all three paths on compare A: flags 0xD, interrupt blocking
      wr(3'd3, 0);
      wr(3'd0, 20); wr(3'd1, 5); wr(3'd2, 5);
      wr(3'd4, trig(8'h17, 8'h17, 8'h17));
      wait_zero();
      wr(3'd5, 32'hF);
      wait_pulse(1, "R5 soca seen", t1);
      chk(irq_o && socb_o, "R5 irq and socb with soca", {irq_o, socb_o}, 3);
      @(negedge clk);
      chk(flags_o == 4'hD, "R8 flag value", flags_o, 13);
      count_pulses(0, 50, n);
      chk(n == 0, "R9 irq held off while flagged", n, 0);
      wr(3'd5, 32'h1);
      chk(flags_o == 4'hC, "R8 w1c clears only bit0", flags_o, 12);
      wait_pulse(0, "R9 irq after clear", t1);
      chk(ctr_o == 5, "R9 irq resumes at match", ctr_o, 5);

      // disabled second strobe
      wr(3'd4, trig(0, 8'h17, 8'h18));
      count_pulses(2, 63, n);
      chk(n == 0, "R6 disabled path silent", n, 0);
      count_pulses(1, 63, n);
      chk(n == 3, "R6 enabled path runs", n, 3);

      // prescale 3 and prescale 0
      wr(3'd4, trig(0, 8'h37, 0));
      wait_pulse(1, "R7 prescale pulse", t1);
      wait_pulse(1, "R7 prescale pulse", t2);
      chk(t2 - t1 == 63, "R7 every third event", t2 - t1, 63);
      wr(3'd4, trig(0, 8'h07, 0));
      count_pulses(1, 70, n);
      chk(n == 0, "R7 prescale zero silent", n, 0);

      // compare beyond period; zero and period events
      wr(3'd1, 50);
      wr(3'd4, trig(0, 8'h17, 8'h13));
      wait_zero(); wait_zero();
      count_pulses(1, 63, n);
      chk(n == 0, "R11 compare above period", n, 0);
      wait_pulse(2, "R5 zero event", t1);
      chk(ctr_o == 0, "R5 zero event at 0", ctr_o, 0);
      wr(3'd4, trig(0, 0, 8'h15));
      wait_pulse(2, "R5 period event", t1);
      chk(ctr_o == 20, "R5 period event at period", ctr_o, 20);

      // compare shadow: new value waits for zero
      wr(3'd1, 5);
      wr(3'd4, trig(0, 8'h17, 0));
      wait_zero();
      wait_pulse(1, "R3 soca", t1);
      wr(3'd1, 15);
      wait_pulse(1, "R3 soca", t2);
      chk(t2 - t1 == 31, "R3 compare loads at zero", t2 - t1, 31);
      chk(ctr_o == 15, "R3 new compare used", ctr_o, 15);

      // period shadow
      wr(3'd0, 30);
      wait_pulse(1, "R4 soca", t3);
      chk(t3 - t2 == 21, "R4 old period finishes", t3 - t2, 21);
      wait_pulse(1, "R4 soca", t1);
      chk(t1 - t3 == 31, "R4 new period after zero", t1 - t3, 31);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule